// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers external inquire (snoop) cycles against two small direct-mapped tag stores: an instruction store whose lines are either valid (shared) or invalid, and a data store whose lines carry a four-state MESI coherence state. An external agent pulses an address strobe together with an inquire line address and an invalidate qualifier. Two clocks later the block reports a registered hit indication. If the matching data line was modified, it also raises a hit-modified indication and a writeback request. The resulting line state depends only on the invalidate qualifier: shared when it is low, invalid when it is high. A modified line moves to its final state only after the writeback has been acknowledged.

The cache controller loads lines through a simple fill port that writes one line's tag and state. Data movement, arbitration, replacement and processor-side accesses stay outside this block. The block accepts one inquiry at a time. A strobe that arrives while an earlier inquiry or its writeback is still in progress is ignored, as is any strobe seen during stop-clock or init.

Top module: `snoop_responder`

## Requirements
- R1: Synchronous reset marks every line of both stores invalid and drives hit, hit-modified and writeback request low; a line filled before reset misses afterwards.
- R2: The hit output changes only at the second rising edge after an accepted strobe and otherwise keeps its value, until two clocks after the next accepted strobe.
- R3: An inquiry hits when its tag matches a valid instruction line or a data line in state S, E or M at the indexed position; an invalid data line or a tag mismatch is a miss and yields hit low.
- R4: A hit with the invalidate qualifier low leaves the line valid: an S, E or M data line becomes S (a later inquiry still hits without hit-modified), and an instruction line stays valid.
- R5: A hit with the invalidate qualifier high on an instruction line or an S or E data line makes the line invalid with no writeback (hit-modified and writeback request stay low).
- R6: A hit on an M data line raises hit-modified and writeback request in the same cycle as hit, with the writeback address equal to the inquire address. Both stay high until writeback acknowledge is sampled high, fall at that edge, and the line then becomes S or I per the sampled qualifier.
- R7: A miss changes no line state, whatever the invalidate qualifier.
- R8: The inquire address and invalidate qualifier are sampled only on the strobe edge; later changes have no effect on that inquiry.
- R9: While stop-clock or init is high, hit is forced low from the next edge, and strobes are ignored; after release hit stays low until the next accepted inquiry completes.
- R10: A strobe is ignored while an inquiry is in flight, that is, from its accepting edge until its result lands and any writeback is acknowledged.
- R11: The fill port writes a line's tag and state at the indexed position of the selected store (select 0 instruction, 1 data); the index is the low 4 address bits by default, and state codes are I=0, S=1, E=2, M=3, with bit 0 meaning valid for the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Stop-clock indication |
| init_i | input | 1 | Init indication |
| eads_i | input | 1 | External inquire address strobe |
| inq_addr_i | input | ADDR_W | Inquire line address |
| inv_i | input | 1 | Invalidate qualifier |
| fill_en_i | input | 1 | Fill write enable |
| fill_dsel_i | input | 1 | Fill store select (0 instruction, 1 data) |
| fill_addr_i | input | ADDR_W | Fill line address |
| fill_state_i | input | 2 | Fill line state code |
| wb_ack_i | input | 1 | Writeback acknowledge |
| hit_o | output | 1 | Inquire hit |
| hitm_o | output | 1 | Inquire hit on a modified line |
| wb_req_o | output | 1 | Writeback request |
| wb_addr_o | output | ADDR_W | Line address to write back |

## Verification
The main pattern table sends inquiries at lines preloaded in each MESI state and at valid and invalid instruction lines, with the qualifier both low and high. It repeats inquiries to the same line so that a follow-up hit or miss, and the presence or absence of hit-modified, reveal the state the first inquiry left behind. A tag mismatch at an occupied index and an invalid data line with a matching tag separate tag comparison from the state check. Directed cases change the address and qualifier right after the strobe, strobe during a pending writeback or in the next cycle, and raise stop-clock and init around a hit.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;
endpackage

// File: rtl/snp_tag_store.sv
module snp_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12,
  parameter int ST_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [ST_W-1:0]  fill_state,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [ST_W-1:0]  upd_state,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic [TAG_W-1:0] cmp_tag,
  output logic             match,
  output logic [ST_W-1:0]  state
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [TAG_W-1:0] rd_tag;
  logic [ST_W-1:0]  st_vec  [DEPTH];

  // tag array: one write port, registered read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[fill_idx] <= fill_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // line states in flops so reset can clear them in one cycle
  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    logic [ST_W-1:0] st_q;
    always_ff @(posedge clk) begin
      if (rst)
        st_q <= '0;
      else if (upd_en && upd_idx == IDX_W'(i))
        st_q <= upd_state;
      else if (fill_en && fill_idx == IDX_W'(i))
        st_q <= fill_state;
    end
    assign st_vec[i] = st_q;
  end

  assign match = (rd_tag == cmp_tag);
  assign state = st_vec[cmp_idx];
endmodule

// File: rtl/snp_wb_ctrl.sv
module snp_wb_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_inv,
  input  logic              ack,
  output logic              pend,
  output logic              done,
  output logic [ADDR_W-1:0] addr,
  output logic              inv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      addr <= '0;
      inv  <= 1'b0;
    end else if (start) begin
      pend <= 1'b1;
      addr <= start_addr;
      inv  <= start_inv;
    end else if (done) begin
      pend <= 1'b0;
    end
  end

  assign done = pend & ack;
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_i,
  input  logic              init_i,
  input  logic              eads_i,
  input  logic [ADDR_W-1:0] inq_addr_i,
  input  logic              inv_i,
  input  logic              fill_en_i,
  input  logic              fill_dsel_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [1:0]        fill_state_i,
  input  logic              wb_ack_i,
  output logic              hit_o,
  output logic              hitm_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o
);
  import snp_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  // stage 1: captured strobe
  logic              s1_v, s1_inv;
  logic [ADDR_W-1:0] s1_addr;
  // stage 2: lookup result
  logic              s2_v, s2_inv, s2_ih, s2_dh, s2_dm;
  logic [ADDR_W-1:0] s2_addr;
  logic              hit_q;

  logic              wb_pend, wb_done, wb_inv;
  logic [ADDR_W-1:0] wb_addr;

  logic inq_busy, inq_accept;
  logic i_match, d_match;
  logic [0:0] i_state;
  logic [1:0] d_state;
  logic i_hit, d_hit, d_mod;

  logic             i_upd_en, d_upd_en;
  logic [0:0]       i_upd_state;
  logic [1:0]       d_upd_state;
  logic [IDX_W-1:0] d_upd_idx;

  assign inq_busy   = s1_v | s2_v | wb_pend;
  assign inq_accept = eads_i & ~inq_busy & ~stop_i & ~init_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_inv  <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_v <= inq_accept;
      if (inq_accept) begin
        s1_addr <= inq_addr_i;
        s1_inv  <= inv_i;
      end
    end
  end

  snp_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(1)) u_istore (
    .clk        (clk),
    .rst        (rst),
    .fill_en    (fill_en_i & ~fill_dsel_i),
    .fill_idx   (fill_addr_i[IDX_W-1:0]),
    .fill_tag   (fill_addr_i[ADDR_W-1:IDX_W]),
    .fill_state (fill_state_i[0:0]),
    .upd_en     (i_upd_en),
    .upd_idx    (s2_addr[IDX_W-1:0]),
    .upd_state  (i_upd_state),
    .rd_idx     (inq_addr_i[IDX_W-1:0]),
    .cmp_idx    (s1_addr[IDX_W-1:0]),
    .cmp_tag    (s1_addr[ADDR_W-1:IDX_W]),
    .match      (i_match),
    .state      (i_state)
  );

  snp_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(2)) u_dstore (
    .clk        (clk),
    .rst        (rst),
    .fill_en    (fill_en_i & fill_dsel_i),
    .fill_idx   (fill_addr_i[IDX_W-1:0]),
    .fill_tag   (fill_addr_i[ADDR_W-1:IDX_W]),
    .fill_state (fill_state_i),
    .upd_en     (d_upd_en),
    .upd_idx    (d_upd_idx),
    .upd_state  (d_upd_state),
    .rd_idx     (inq_addr_i[IDX_W-1:0]),
    .cmp_idx    (s1_addr[IDX_W-1:0]),
    .cmp_tag    (s1_addr[ADDR_W-1:IDX_W]),
    .match      (d_match),
    .state      (d_state)
  );

  assign i_hit = s1_v & i_match & i_state[0];
  assign d_hit = s1_v & d_match & (d_state != ST_I);
  assign d_mod = (d_state == ST_M);

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v    <= 1'b0;
      s2_inv  <= 1'b0;
      s2_ih   <= 1'b0;
      s2_dh   <= 1'b0;
      s2_dm   <= 1'b0;
      s2_addr <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_inv  <= s1_inv;
        s2_ih   <= i_hit;
        s2_dh   <= d_hit;
        s2_dm   <= d_hit & d_mod;
        s2_addr <= s1_addr;
      end
    end
  end

  // hit output register: forced low in stop-clock and init
  always_ff @(posedge clk) begin
    if (rst || stop_i || init_i)
      hit_q <= 1'b0;
    else if (s2_v)
      hit_q <= s2_ih | s2_dh;
  end

  snp_wb_ctrl #(.ADDR_W(ADDR_W)) u_wb (
    .clk        (clk),
    .rst        (rst),
    .start      (s2_v & s2_dm),
    .start_addr (s2_addr),
    .start_inv  (s2_inv),
    .ack        (wb_ack_i),
    .pend       (wb_pend),
    .done       (wb_done),
    .addr       (wb_addr),
    .inv        (wb_inv)
  );

  // state updates: immediate for clean lines, after acknowledge for modified
  assign i_upd_en    = s2_v & s2_ih;
  assign i_upd_state = ~s2_inv;
  assign d_upd_en    = (s2_v & s2_dh & ~s2_dm) | wb_done;
  assign d_upd_idx   = wb_done ? wb_addr[IDX_W-1:0] : s2_addr[IDX_W-1:0];
  assign d_upd_state = (wb_done ? wb_inv : s2_inv) ? ST_I : ST_S;

  assign hit_o     = hit_q;
  assign hitm_o    = wb_pend;
  assign wb_req_o  = wb_pend;
  assign wb_addr_o = wb_addr;
endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk (
  input logic clk,
  input logic rst,
  input logic stop_i,
  input logic init_i,
  input logic wb_ack_i,
  input logic hit_o,
  input logic hitm_o,
  input logic inq_accept
);
  // R2: hit moves only three samples after an accepted strobe, or after stop/init
  a_r2_hit_change_timed: assert property (@(posedge clk) disable iff (rst)
    (hit_o != $past(hit_o)) |-> ($past(inq_accept, 3) || $past(stop_i) || $past(init_i)));

  // R6: hit-modified rises together with hit
  a_r6_hitm_with_hit: assert property (@(posedge clk) disable iff (rst)
    ($rose(hitm_o) && !$past(stop_i) && !$past(init_i)) |-> hit_o);

  // R6: hit-modified only ever comes from an accepted inquiry
  a_r6_hitm_source: assert property (@(posedge clk) disable iff (rst)
    $rose(hitm_o) |-> $past(inq_accept, 3));

  // R6: held until acknowledge
  a_r6_hitm_holds: assert property (@(posedge clk) disable iff (rst)
    (hitm_o && !wb_ack_i) |=> hitm_o);

  // R6: released on acknowledge
  a_r6_hitm_release: assert property (@(posedge clk) disable iff (rst)
    (hitm_o && wb_ack_i) |=> !hitm_o);

  // R9: stop-clock or init forces hit low
  a_r9_forced_low: assert property (@(posedge clk) disable iff (rst)
    (stop_i || init_i) |=> !hit_o);
endmodule

bind snoop_responder snoop_responder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .stop_i     (stop_i),
  .init_i     (init_i),
  .wb_ack_i   (wb_ack_i),
  .hit_o      (hit_o),
  .hitm_o     (hitm_o),
  .inq_accept (inq_accept)
);

// File: tb/tb_snoop_responder.sv
module tb_snoop_responder;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_i = 1'b0, init_i = 1'b0, eads_i = 1'b0, inv_i = 1'b0;
  logic [AW-1:0] inq_addr_i = '0, fill_addr_i = '0;
  logic fill_en_i = 1'b0, fill_dsel_i = 1'b0, wb_ack_i = 1'b0;
  logic [1:0] fill_state_i = '0;
  logic hit_o, hitm_o, wb_req_o;
  logic [AW-1:0] wb_addr_o;

  int n_chk = 0, n_bad = 0;
  logic last_hit = 1'b0;

  always #4 clk = ~clk;

  snoop_responder #(.ADDR_W(AW), .IDX_W(4)) dut (
    .clk(clk), .rst(rst), .stop_i(stop_i), .init_i(init_i), .eads_i(eads_i),
    .inq_addr_i(inq_addr_i), .inv_i(inv_i), .fill_en_i(fill_en_i),
    .fill_dsel_i(fill_dsel_i), .fill_addr_i(fill_addr_i), .fill_state_i(fill_state_i),
    .wb_ack_i(wb_ack_i), .hit_o(hit_o), .hitm_o(hitm_o), .wb_req_o(wb_req_o),
    .wb_addr_o(wb_addr_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic dsel, input logic [AW-1:0] a, input logic [1:0] st);
    @(negedge clk);
    fill_en_i = 1'b1; fill_dsel_i = dsel; fill_addr_i = a; fill_state_i = st;
    @(negedge clk);
    fill_en_i = 1'b0;
  endtask

  // strobe, then scramble address/qualifier (R8), check old value at +1, new at +2
  task automatic inquire(input logic [AW-1:0] a, input logic v, input logic eh,
                         input logic em, input string rq);
    @(negedge clk);
    eads_i = 1'b1; inq_addr_i = a; inv_i = v;
    @(negedge clk);
    eads_i = 1'b0; inq_addr_i = ~a; inv_i = ~v;
    @(negedge clk);
    chk(hit_o == last_hit, {rq, " R2 hit held one clock"}, 32'(hit_o), 32'(last_hit));
    @(negedge clk);
    chk(hit_o == eh, {rq, " hit"}, 32'(hit_o), 32'(eh));
    chk(hitm_o == em && wb_req_o == em, {rq, " hitm/wbreq"}, {hitm_o, wb_req_o}, {em, em});
    last_hit = eh;
    if (em) begin
      chk(wb_addr_o == a, {rq, " R6 wb addr"}, 32'(wb_addr_o), 32'(a));
      repeat (3) @(negedge clk);
      chk(hitm_o && wb_req_o && hit_o, {rq, " R6 hold until ack"}, {hit_o, hitm_o, wb_req_o}, 3'b111);
      wb_ack_i = 1'b1;
      @(negedge clk);
      wb_ack_i = 1'b0;
      chk(!hitm_o && !wb_req_o, {rq, " R6 release on ack"}, {hitm_o, wb_req_o}, 0);
    end
    @(negedge clk);
  endtask

  // {addr, inv, exp_hit, exp_hitm}
  localparam logic [AW+2:0] VEC [16] = '{
    {16'hA001, 1'b0, 1'b1, 1'b1},  // R6 M hit, qualifier low -> S
    {16'hA001, 1'b0, 1'b1, 1'b0},  // R4 now S: hit, no writeback
    {16'hA002, 1'b1, 1'b1, 1'b0},  // R5 E invalidated, no writeback
    {16'hA002, 1'b0, 1'b0, 1'b0},  // R5 now invalid
    {16'hA003, 1'b1, 1'b1, 1'b0},  // R5 S invalidated
    {16'hA003, 1'b0, 1'b0, 1'b0},  // R5 now invalid
    {16'hB004, 1'b0, 1'b1, 1'b0},  // R3 instruction hit, R4 stays valid
    {16'hB004, 1'b1, 1'b1, 1'b0},  // R4 still valid; now invalidated
    {16'hB004, 1'b0, 1'b0, 1'b0},  // R5 instruction line invalid
    {16'hC005, 1'b0, 1'b0, 1'b0},  // R3 tag match on invalid data line
    {16'hD001, 1'b1, 1'b0, 1'b0},  // R3 R7 tag mismatch with qualifier high
    {16'hA001, 1'b0, 1'b1, 1'b0},  // R7 line untouched by the miss
    {16'hA006, 1'b1, 1'b1, 1'b1},  // R6 M hit both stores, qualifier high -> I
    {16'hA006, 1'b0, 1'b0, 1'b0},  // R6 both lines invalid now
    {16'hA001, 1'b1, 1'b1, 1'b0},  // R5 S invalidated
    {16'hA001, 1'b0, 1'b0, 1'b0}   // R5 invalid
  };

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fill(1'b1, 16'hA001, 2'd3);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(!hit_o && !hitm_o && !wb_req_o, "R1 outputs after reset", {hit_o, hitm_o, wb_req_o}, 0);
    inquire(16'hA001, 1'b0, 1'b0, 1'b0, "R1 line cleared by reset");

    // R11 preload through the fill port
    fill(1'b1, 16'hA001, 2'd3);
    fill(1'b1, 16'hA002, 2'd2);
    fill(1'b1, 16'hA003, 2'd1);
    fill(1'b0, 16'hB004, 2'd1);
    fill(1'b1, 16'hC005, 2'd0);
    fill(1'b1, 16'hA006, 2'd3);
    fill(1'b0, 16'hA006, 2'd1);

    for (int i = 0; i < 16; i++) begin
      logic [AW+2:0] v;
      v = VEC[i];
      inquire(v[AW+2:3], v[2], v[1], v[0], $sformatf("R11 vec%0d", i));
    end

    // R8 qualifier flipped high right after the strobe must not invalidate
    fill(1'b1, 16'hA007, 2'd3);
    inquire(16'hA007, 1'b0, 1'b1, 1'b1, "R8 M hit");
    inquire(16'hA007, 1'b0, 1'b1, 1'b0, "R8 line kept as S");

    // R10 back-to-back strobe ignored
    @(negedge clk); eads_i = 1'b1; inq_addr_i = 16'h1234; inv_i = 1'b0;
    @(negedge clk); inq_addr_i = 16'hA007;
    @(negedge clk); eads_i = 1'b0;
    @(negedge clk);
    chk(hit_o == 1'b0, "R10 first inquiry miss", 32'(hit_o), 0);
    repeat (3) @(negedge clk);
    chk(hit_o == 1'b0, "R10 second strobe ignored", 32'(hit_o), 0);
    last_hit = 1'b0;

    // R10 strobe during pending writeback ignored
    fill(1'b1, 16'hA008, 2'd3);
    @(negedge clk); eads_i = 1'b1; inq_addr_i = 16'hA008; inv_i = 1'b1;
    @(negedge clk); eads_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(hitm_o == 1'b1, "R10 writeback pending", 32'(hitm_o), 1);
    eads_i = 1'b1; inq_addr_i = 16'hA007; inv_i = 1'b1;
    @(negedge clk); eads_i = 1'b0;
    repeat (2) @(negedge clk);
    wb_ack_i = 1'b1;
    @(negedge clk); wb_ack_i = 1'b0;
    last_hit = 1'b1;
    inquire(16'hA007, 1'b0, 1'b1, 1'b0, "R10 line not invalidated");
    inquire(16'hA008, 1'b0, 1'b0, 1'b0, "R6 invalidated after ack");

    // R9 stop-clock and init
    inquire(16'hA007, 1'b0, 1'b1, 1'b0, "R9 setup hit");
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk);
    chk(hit_o == 1'b0, "R9 stop forces hit low", 32'(hit_o), 0);
    eads_i = 1'b1; inq_addr_i = 16'hA007; inv_i = 1'b1;
    @(negedge clk); eads_i = 1'b0; stop_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(hit_o == 1'b0, "R9 low after stop release", 32'(hit_o), 0);
    last_hit = 1'b0;
    inquire(16'hA007, 1'b0, 1'b1, 1'b0, "R9 strobe in stop ignored");
    @(negedge clk); init_i = 1'b1;
    @(negedge clk);
    chk(hit_o == 1'b0, "R9 init forces hit low", 32'(hit_o), 0);
    init_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(hit_o == 1'b0, "R9 low after init release", 32'(hit_o), 0);
    last_hit = 1'b0;
    inquire(16'hA007, 1'b1, 1'b1, 1'b0, "R9 normal after init");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule